// File: doc/BRIEF.md
# PLL Retune Sequencer

This block moves a clock PLL to a new output frequency without software stepping through the procedure. A single-cycle `start` strobe together with a requested frequency in MHz (`req_mhz`) is accepted while the block is idle. The request is mapped onto a table of 21 supported settings, spaced 25 MHz apart from 500 MHz to 1000 MHz. The block then drives the PLL control words and reset line through a fixed, timed procedure. All delays are counted in pulses of `us_tick`, which the surrounding clocking logic raises for one cycle every microsecond.

The procedure is a chain of named states:

- `ST_IDLE` moves to `ST_BYP_SET` on an accepted start.
- `ST_BYP_SET` forces the bypass bit on and moves to `ST_BYP_WAIT`, which waits 10 ticks.
- `ST_RST_SET` raises the PLL reset and moves to `ST_RST_WAIT`, which waits 10 ticks.
- `ST_PROGRAM` writes all four control words and moves to `ST_PROG_WAIT`, which waits 10 ticks.
- `ST_RST_CLR` drops the reset and moves to `ST_LOCK_WAIT`, which waits 100 ticks.
- `ST_BYP_CLR` removes bypass, pulses `done` and returns to `ST_IDLE`.

Each wait state leaves on the tick that completes its count. Each action state lasts one cycle. The frequency actually chosen is reported on `sel_mhz`.

Top module: `pll_retune_seq`

## Requirements
- R1: While `rst_n` is low and after its release, `ctrl0`..`ctrl3`, `pll_rst`, `busy`, `done` and `sel_mhz` are all zero.
- R2: A start accepted at clock edge E sets `sel_mhz` from edge E onward. The value is 500 + 25*idx, where idx = floor((req_mhz - 500)/25), so requests between table points round down.
- R3: A request below 500, or one whose idx is 21 or more (req_mhz of 1025 and above), selects idx 0 and reports 500.
- R4: One edge after acceptance, bit 1 of `ctrl0` (bypass) is set and every other bit of `ctrl0` is kept. `pll_rst` stays low at that edge and is only ever high while bypass is set.
- R5: `pll_rst` rises after exactly 10 ticks counted from the edge that set bypass.
- R6: `pll_rst` stays high for exactly 20 ticks. It falls with the control words programmed as follows:
  - `ctrl0` = refdiv<<8 | outdiv<<4 | bit 3 | bit 1, with bits 31:16, 2 and 0 zero.
  - `ctrl1` = fbdiv.
  - `ctrl2` = bwadj<<16 | sfreq.
  - `ctrl3` = sslope.
- R7: Every table entry satisfies fbdiv*50 = mhz*(refdiv+1)*(outdiv+1)*65536 and bwadj = (fbdiv>>15) - 1. The entries for 500, 700 and 1000 MHz are (refdiv, outdiv, fbdiv, bwadj, sfreq, sslope):
  - 500 MHz: (1, 2, 3932160, 119, 208, 189).
  - 700 MHz: (0, 0, 917504, 27, 416, 22).
  - 1000 MHz: (2, 0, 3932160, 119, 139, 283).
- R8: Exactly 100 ticks after `pll_rst` falls, bypass clears. In that same edge `done` is high and `busy` is low, and `done` is low again on the next edge. The other `ctrl0` bits keep their programmed values.
- R9: A start pulse while `busy` is high changes neither `sel_mhz` nor the control words.
- R10: `busy` is high from the acceptance edge until the edge that raises `done`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| us_tick | input | 1 | One-cycle strobe each microsecond |
| start | input | 1 | Request a retune (taken only when idle) |
| req_mhz | input | 11 | Requested frequency in MHz |
| ctrl0 | output | 32 | PLL control word 0 (dividers, saturation, bypass) |
| ctrl1 | output | 32 | PLL control word 1 (feedback divider) |
| ctrl2 | output | 32 | PLL control word 2 (bandwidth, spread frequency) |
| ctrl3 | output | 32 | PLL control word 3 (spread slope) |
| pll_rst | output | 1 | PLL reset, active high |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle completion pulse |
| sel_mhz | output | 11 | Frequency actually chosen |

## Verification
The assertions assume that `us_tick` never stays high for two adjacent cycles. With that gap, a tick cannot land in the single action cycle that follows each completed wait. This keeps every measured interval equal to its programmed count.

The stimulus respects this by spacing ticks three to six cycles apart, with the spacing drawn per run from a fixed seed. `start` is always a one-cycle pulse, and the stray pulses sent mid-sequence arrive only during the lock wait. Requested values cover both table ends, both off-range sides, points between table steps and a spread of random values from 400 to 1100.

// File: rtl/pll_retune_pkg.sv
package pll_retune_pkg;

    localparam int WORD_W = 32;

    typedef struct packed {
        logic [7:0]  refdiv;
        logic [3:0]  outdiv;
        logic [31:0] fbdiv;
        logic [15:0] bwadj;
        logic [15:0] sfreq;
        logic [31:0] sslope;
    } pll_cfg_t;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_BYP_SET,
        ST_BYP_WAIT,
        ST_RST_SET,
        ST_RST_WAIT,
        ST_PROGRAM,
        ST_PROG_WAIT,
        ST_RST_CLR,
        ST_LOCK_WAIT,
        ST_BYP_CLR
    } seq_state_t;

endpackage

// File: rtl/pll_freq_select.sv
module pll_freq_select #(
    parameter int REQ_W     = 11,
    parameter int LOW_MHZ   = 500,
    parameter int STEP_MHZ  = 25,
    parameter int N_ENTRIES = 21,
    parameter int IDX_W     = 5
) (
    input  logic [REQ_W-1:0] req_mhz,
    output logic [IDX_W-1:0] idx,
    output logic [REQ_W-1:0] mhz
);
    logic [REQ_W-1:0] offset;
    logic [REQ_W-1:0] quot;
    logic             in_range;

    assign offset   = req_mhz - REQ_W'(LOW_MHZ);
    assign quot     = offset / REQ_W'(STEP_MHZ);
    // Reject below the table and any index equal to or past the entry count
    assign in_range = (req_mhz >= REQ_W'(LOW_MHZ)) && (quot < REQ_W'(N_ENTRIES));
    assign idx      = in_range ? IDX_W'(quot) : '0;
    assign mhz      = REQ_W'(LOW_MHZ) + REQ_W'(STEP_MHZ) * REQ_W'(idx);

    always_comb begin
        assert (mhz >= REQ_W'(LOW_MHZ)) else $error("assert_sel_floor_R3");
    end
endmodule

// File: rtl/pll_cfg_rom.sv
module pll_cfg_rom
    import pll_retune_pkg::*;
#(
    parameter int IDX_W = 5
) (
    input  logic [IDX_W-1:0] idx,
    output pll_cfg_t         cfg
);
    function automatic pll_cfg_t row(input logic [7:0] r, input logic [3:0] o,
                                     input logic [31:0] fb, input logic [15:0] bw,
                                     input logic [15:0] sf, input logic [31:0] ss);
        pll_cfg_t c;
        c.refdiv = r;
        c.outdiv = o;
        c.fbdiv  = fb;
        c.bwadj  = bw;
        c.sfreq  = sf;
        c.sslope = ss;
        return c;
    endfunction

    always_comb begin
        unique case (int'(idx))
            1:       cfg = row(2, 1, 32'd4128768, 16'd125, 16'd139, 32'd297);
            2:       cfg = row(2, 1, 32'd4325376, 16'd131, 16'd139, 32'd311);
            3:       cfg = row(2, 1, 32'd4521984, 16'd137, 16'd139, 32'd326);
            4:       cfg = row(2, 1, 32'd4718592, 16'd143, 16'd138, 32'd339);
            5:       cfg = row(1, 1, 32'd3276800, 16'd99,  16'd208, 32'd157);
            6:       cfg = row(1, 1, 32'd3407872, 16'd103, 16'd208, 32'd164);
            7:       cfg = row(1, 1, 32'd3538944, 16'd107, 16'd208, 32'd170);
            8:       cfg = row(0, 0, 32'd917504,  16'd27,  16'd416, 32'd22);
            9:       cfg = row(1, 1, 32'd3801088, 16'd115, 16'd208, 32'd182);
            10:      cfg = row(0, 0, 32'd983040,  16'd29,  16'd416, 32'd23);
            11:      cfg = row(3, 0, 32'd4063232, 16'd123, 16'd104, 32'd390);
            12:      cfg = row(3, 0, 32'd4194304, 16'd127, 16'd104, 32'd403);
            13:      cfg = row(3, 0, 32'd4325376, 16'd131, 16'd104, 32'd415);
            14:      cfg = row(2, 0, 32'd3342336, 16'd101, 16'd139, 32'd241);
            15:      cfg = row(2, 0, 32'd3440640, 16'd104, 16'd139, 32'd248);
            16:      cfg = row(2, 0, 32'd3538944, 16'd107, 16'd139, 32'd255);
            17:      cfg = row(2, 0, 32'd3637248, 16'd110, 16'd139, 32'd262);
            18:      cfg = row(2, 0, 32'd3735552, 16'd113, 16'd139, 32'd269);
            19:      cfg = row(2, 0, 32'd3833856, 16'd116, 16'd139, 32'd276);
            20:      cfg = row(2, 0, 32'd3932160, 16'd119, 16'd139, 32'd283);
            default: cfg = row(1, 2, 32'd3932160, 16'd119, 16'd208, 32'd189);
        endcase
    end
endmodule

// File: rtl/pll_us_timer.sv
module pll_us_timer #(
    parameter int CNT_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             tick,
    output logic             expire
);
    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                  cnt <= '0;
        else if (load)               cnt <= load_val;
        else if (tick && cnt != '0)  cnt <= cnt - 1'b1;
    end

    // Fires on the tick that completes the count
    assign expire = tick && (cnt == CNT_W'(1));

    assert property (@(posedge clk) disable iff (!rst_n)
        (cnt == '0 && !load) |=> (cnt == '0))
        else $error("assert_timer_no_wrap_R5");
endmodule

// File: rtl/pll_retune_seq.sv
module pll_retune_seq
    import pll_retune_pkg::*;
#(
    parameter int REQ_W     = 11,
    parameter int LOW_MHZ   = 500,
    parameter int STEP_MHZ  = 25,
    parameter int N_ENTRIES = 21,
    parameter int T_BYP     = 10,
    parameter int T_RST     = 10,
    parameter int T_PROG    = 10,
    parameter int T_LOCK    = 100
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              us_tick,
    input  logic              start,
    input  logic [REQ_W-1:0]  req_mhz,
    output logic [WORD_W-1:0] ctrl0,
    output logic [WORD_W-1:0] ctrl1,
    output logic [WORD_W-1:0] ctrl2,
    output logic [WORD_W-1:0] ctrl3,
    output logic              pll_rst,
    output logic              busy,
    output logic              done,
    output logic [REQ_W-1:0]  sel_mhz
);
    localparam int IDX_W    = $clog2(N_ENTRIES);
    localparam int MAX_WAIT = (T_LOCK > T_BYP ? T_LOCK : T_BYP) > (T_RST > T_PROG ? T_RST : T_PROG)
                            ? (T_LOCK > T_BYP ? T_LOCK : T_BYP) : (T_RST > T_PROG ? T_RST : T_PROG);
    localparam int CNT_W    = $clog2(MAX_WAIT + 1);
    localparam int BYP_BIT  = 1;

    seq_state_t       state, state_nx;
    logic [IDX_W-1:0] req_idx, idx_q;
    logic [REQ_W-1:0] req_sel;
    pll_cfg_t         cfg;
    logic             t_load, t_expire;
    logic [CNT_W-1:0] t_val;

    pll_freq_select #(
        .REQ_W(REQ_W), .LOW_MHZ(LOW_MHZ), .STEP_MHZ(STEP_MHZ),
        .N_ENTRIES(N_ENTRIES), .IDX_W(IDX_W)
    ) u_sel (
        .req_mhz(req_mhz), .idx(req_idx), .mhz(req_sel)
    );

    pll_cfg_rom #(.IDX_W(IDX_W)) u_rom (.idx(idx_q), .cfg(cfg));

    pll_us_timer #(.CNT_W(CNT_W)) u_tmr (
        .clk(clk), .rst_n(rst_n), .load(t_load), .load_val(t_val),
        .tick(us_tick), .expire(t_expire)
    );

    // Timer loads in each action state that precedes a wait
    always_comb begin
        t_load = 1'b1;
        unique case (state)
            ST_BYP_SET: t_val = CNT_W'(T_BYP);
            ST_RST_SET: t_val = CNT_W'(T_RST);
            ST_PROGRAM: t_val = CNT_W'(T_PROG);
            ST_RST_CLR: t_val = CNT_W'(T_LOCK);
            default: begin
                t_load = 1'b0;
                t_val  = '0;
            end
        endcase
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:      if (start)    state_nx = ST_BYP_SET;
            ST_BYP_SET:                 state_nx = ST_BYP_WAIT;
            ST_BYP_WAIT:  if (t_expire) state_nx = ST_RST_SET;
            ST_RST_SET:                 state_nx = ST_RST_WAIT;
            ST_RST_WAIT:  if (t_expire) state_nx = ST_PROGRAM;
            ST_PROGRAM:                 state_nx = ST_PROG_WAIT;
            ST_PROG_WAIT: if (t_expire) state_nx = ST_RST_CLR;
            ST_RST_CLR:                 state_nx = ST_LOCK_WAIT;
            ST_LOCK_WAIT: if (t_expire) state_nx = ST_BYP_CLR;
            ST_BYP_CLR:                 state_nx = ST_IDLE;
            default:                    state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl0   <= '0;
            ctrl1   <= '0;
            ctrl2   <= '0;
            ctrl3   <= '0;
            pll_rst <= 1'b0;
            busy    <= 1'b0;
            done    <= 1'b0;
            sel_mhz <= '0;
            idx_q   <= '0;
        end else begin
            done <= 1'b0;
            unique case (state)
                ST_IDLE: if (start) begin
                    idx_q   <= req_idx;
                    sel_mhz <= req_sel;
                    busy    <= 1'b1;
                end
                ST_BYP_SET: ctrl0[BYP_BIT] <= 1'b1;
                ST_RST_SET: pll_rst <= 1'b1;
                ST_PROGRAM: begin
                    ctrl0 <= {16'b0, cfg.refdiv, cfg.outdiv, 4'b1010};
                    ctrl1 <= cfg.fbdiv;
                    ctrl2 <= {cfg.bwadj, cfg.sfreq};
                    ctrl3 <= cfg.sslope;
                end
                ST_RST_CLR: pll_rst <= 1'b0;
                ST_BYP_CLR: begin
                    ctrl0[BYP_BIT] <= 1'b0;
                    done           <= 1'b1;
                    busy           <= 1'b0;
                end
                default: ;
            endcase
        end
    end

    assert property (@(posedge clk) disable iff (!rst_n) done |=> !done)
        else $error("assert_done_single_R8");
    assert property (@(posedge clk) disable iff (!rst_n) done |-> !busy)
        else $error("assert_done_not_busy_R8");
    assert property (@(posedge clk) disable iff (!rst_n) $fell(ctrl0[BYP_BIT]) |-> done)
        else $error("assert_unbypass_with_done_R8");
    assert property (@(posedge clk) disable iff (!rst_n) pll_rst |-> ctrl0[BYP_BIT])
        else $error("assert_reset_while_bypassed_R4");
    assert property (@(posedge clk) disable iff (!rst_n) (busy && start) |=> $stable(sel_mhz))
        else $error("assert_start_ignored_R9");
    assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (sel_mhz >= REQ_W'(LOW_MHZ) && sel_mhz <= REQ_W'(LOW_MHZ + STEP_MHZ*(N_ENTRIES-1))))
        else $error("assert_sel_in_table_R3");
endmodule

// File: tb/sim_pll_retune_seq.sv
`timescale 1ns/1ps
module sim_pll_retune_seq;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick = 1'b0;
    logic        start = 1'b0;
    logic [10:0] req = '0;
    logic [31:0] ctrl0, ctrl1, ctrl2, ctrl3;
    logic        pll_rst, busy, done;
    logic [10:0] sel_mhz;

    int checks = 0;
    int fails  = 0;
    int tick_acc = 0;
    int per = 4;
    int phase = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    pll_retune_seq u0 (
        .clk(clk), .rst_n(rst_n), .us_tick(tick), .start(start), .req_mhz(req),
        .ctrl0(ctrl0), .ctrl1(ctrl1), .ctrl2(ctrl2), .ctrl3(ctrl3),
        .pll_rst(pll_rst), .busy(busy), .done(done), .sel_mhz(sel_mhz)
    );

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Advance to the next falling edge; count the tick the last rising edge saw
    task automatic step();
        @(negedge clk);
        tick_acc += int'(tick);
        if (phase >= per - 1) begin
            tick  = 1'b1;
            phase = 0;
        end else begin
            tick  = 1'b0;
            phase++;
        end
    endtask

    function automatic int exp_sel(input int r);
        int i;
        if (r < 500) return 500;
        i = (r - 500) / 25;
        if (i >= 21) return 500;
        return 500 + 25 * i;
    endfunction

    task automatic run_seq(input int r, input int p, input bit poke);
        int em;
        int n;
        logic [31:0] prev0, prog0, prog1, prog2, prog3;
        longint rdv, odv;
        bit busy_ok;
        em = exp_sel(r);
        per = p;
        prev0 = ctrl0;
        busy_ok = 1'b1;
        req = 11'(r);
        start = 1'b1;
        step();
        start = 1'b0;
        chk(busy == 1'b1, "R10 busy after start", longint'(busy), 1);
        chk(int'(sel_mhz) == em, "R2/R3 sel_mhz", longint'(sel_mhz), longint'(em));
        chk(ctrl0 == prev0, "R4 ctrl0 before bypass", longint'(ctrl0), longint'(prev0));
        step();
        chk(ctrl0 == (prev0 | 32'h2), "R4 bypass set keeps bits", longint'(ctrl0), longint'(prev0 | 32'h2));
        chk(pll_rst == 1'b0, "R4 reset low at bypass", longint'(pll_rst), 0);
        tick_acc = 0;
        n = 0;
        while (!pll_rst && n < 5000) begin step(); n++; if (!busy) busy_ok = 1'b0; end
        chk(tick_acc == 10, "R5 ticks bypass to reset", tick_acc, 10);
        tick_acc = 0;
        n = 0;
        while (pll_rst && n < 5000) begin step(); n++; if (!busy) busy_ok = 1'b0; end
        chk(tick_acc == 20, "R6 reset width ticks", tick_acc, 20);
        prog0 = ctrl0; prog1 = ctrl1; prog2 = ctrl2; prog3 = ctrl3;
        chk((ctrl0 & 32'hFFFF_000F) == 32'hA, "R6 ctrl0 fixed bits", longint'(ctrl0 & 32'hFFFF_000F), 10);
        rdv = longint'(ctrl0[15:8]);
        odv = longint'(ctrl0[7:4]);
        chk(longint'(ctrl1) * 50 == longint'(em) * (rdv + 1) * (odv + 1) * 65536,
            "R7 fbdiv relation", longint'(ctrl1), longint'(em) * (rdv + 1) * (odv + 1) * 65536 / 50);
        chk(longint'(ctrl2[31:16]) == longint'(ctrl1 >> 15) - 1, "R7 bwadj relation",
            longint'(ctrl2[31:16]), longint'(ctrl1 >> 15) - 1);
        if (em == 500) begin
            chk(ctrl0 == 32'h12A && ctrl1 == 32'd3932160, "R7 500 ctrl0/1", longint'(ctrl0), 32'h12A);
            chk(ctrl2 == ((32'd119 << 16) | 32'd208) && ctrl3 == 32'd189, "R7 500 ctrl2/3", longint'(ctrl3), 189);
        end
        if (em == 700) begin
            chk(ctrl0 == 32'h00A && ctrl1 == 32'd917504, "R7 700 ctrl0/1", longint'(ctrl0), 32'h00A);
            chk(ctrl2 == ((32'd27 << 16) | 32'd416) && ctrl3 == 32'd22, "R7 700 ctrl2/3", longint'(ctrl3), 22);
        end
        if (em == 1000) begin
            chk(ctrl0 == 32'h20A && ctrl1 == 32'd3932160, "R7 1000 ctrl0/1", longint'(ctrl0), 32'h20A);
            chk(ctrl2 == ((32'd119 << 16) | 32'd139) && ctrl3 == 32'd283, "R7 1000 ctrl2/3", longint'(ctrl3), 283);
        end
        tick_acc = 0;
        n = 0;
        while (!done && n < 5000) begin
            step();
            n++;
            if (poke && n == 30) begin
                req = 11'(em == 800 ? 600 : 800);
                start = 1'b1;
            end else begin
                start = 1'b0;
            end
            if (!done && !busy) busy_ok = 1'b0;
        end
        start = 1'b0;
        chk(tick_acc == 100, "R8 lock wait ticks", tick_acc, 100);
        chk(ctrl0 == (prog0 & ~32'h2), "R8 bypass cleared, rest kept", longint'(ctrl0), longint'(prog0 & ~32'h2));
        chk(busy == 1'b0 && pll_rst == 1'b0, "R8 busy low with done", longint'(busy), 0);
        chk(busy_ok, "R10 busy held through sequence", longint'(busy_ok), 1);
        if (poke) begin
            chk(int'(sel_mhz) == em, "R9 sel unchanged by busy start", longint'(sel_mhz), longint'(em));
            chk(ctrl1 == prog1 && ctrl2 == prog2 && ctrl3 == prog3, "R9 words unchanged",
                longint'(ctrl1), longint'(prog1));
        end
        step();
        chk(done == 1'b0, "R8 done single cycle", longint'(done), 0);
        chk(busy == 1'b0 && ctrl0 == (prog0 & ~32'h2), "R9 no restart after busy start",
            longint'(busy), 0);
        step();
    endtask

    initial begin
        void'($urandom(32'd1234));
        repeat (3) step();
        chk(ctrl0 == 0 && ctrl1 == 0 && ctrl2 == 0 && ctrl3 == 0, "R1 words in reset", longint'(ctrl0), 0);
        chk(!pll_rst && !busy && !done && sel_mhz == 0, "R1 flags in reset", longint'(busy), 0);
        rst_n = 1'b1;
        step();
        step();
        chk(!pll_rst && !busy && !done && ctrl0 == 0 && sel_mhz == 0, "R1 idle after reset", longint'(ctrl0), 0);
        run_seq(500, 4, 1'b0);
        run_seq(700, 3, 1'b1);
        run_seq(1000, 5, 1'b0);
        run_seq(499, 3, 1'b0);
        run_seq(0, 4, 1'b0);
        run_seq(1024, 6, 1'b0);
        run_seq(1025, 3, 1'b0);
        run_seq(2047, 4, 1'b1);
        run_seq(549, 5, 1'b0);
        run_seq(524, 3, 1'b0);
        for (int k = 0; k < 12; k++) begin
            run_seq(int'($urandom_range(1100, 400)), int'($urandom_range(6, 3)), 1'($urandom_range(1, 0)));
        end
        if (!finished) begin
            finished = 1'b1;
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        #(4 * 200000);
        if (!finished) begin
            finished = 1'b1;
            checks++;
            fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule